// File: doc/BRIEF.md
# Spike Sorter Mode Controller

This block is the command front end of a spike-sorting unit. A three-bit mode input chooses what the unit does on every clock. The unit can load principal-component coefficients, write a control register, read one back, pass samples to the sorting datapath, do nothing, or return to its initial state.

The block holds two coefficient banks, one per principal component. Each bank is as deep as a spike. Coefficients arrive one after another on the shared sample input, and a select bit chooses the bank that receives them. The block also holds a file of addressed control registers. The sorting datapath reads both stores through the block's outputs: it fetches coefficients through an addressed, registered read port, and it sees the control-register file as a flat vector.

Top module: `spk_mode_ctrl`

## Requirements
- R1: The mode code is 0 idle, 1 coefficient load, 2 register write, 3 register read, 4 sort and 7 reset. Codes 5 and 6 behave exactly as idle.
- R2: In load mode, each cycle with `smp_vld_i` high stores `smp_data_i` into the bank chosen by `pc_sel_i` (0 selects bank 0 for the first component, 1 selects bank 1 for the second) at that bank's pointer. That pointer then advances by one. Cycles with `smp_vld_i` low store nothing and do not advance the pointer.
- R3: The two banks have independent pointers. A pointer wraps from `SPK_LEN-1` back to 0.
- R4: Both pointers return to 0 whenever the mode is not load, and on reset. A new load session therefore starts at index 0.
- R5: In write mode, the register at `cr_addr_i` takes `cr_wdata_i` at the clock edge. Register k occupies bits `[k*CR_W +: CR_W]` of `cfg_o`.
- R6: In read mode, `cr_rdata_o` shows the register at `cr_addr_i` one cycle later. Outside read mode it holds its last value.
- R7: In sort mode, `sort_en_o` is high one cycle after the mode is applied. `sort_vld_o` and `sort_data_o` forward `smp_vld_i` and `smp_data_i` with one cycle of latency. `sort_vld_o` is low outside sort mode.
- R8: In idle mode, no control register, coefficient or read-data value changes, whatever the other inputs do.
- R9: Reset, by the `rst` pin or by mode 7, clears all control registers, both pointers, `cr_rdata_o` and the sort outputs. Coefficient contents are kept.
- R10: `coef_o` returns the coefficient at `coef_addr_i` of every bank one cycle later, with bank b at bits `[b*SMP_W +: SMP_W]`. When a load writes the same index in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode code |
| smp_vld_i | input | 1 | Sample/data valid |
| smp_data_i | input | SMP_W | Shared sample and coefficient data |
| pc_sel_i | input | 1 | Coefficient bank select |
| cr_addr_i | input | $clog2(N_CR) | Control register address |
| cr_wdata_i | input | CR_W | Control register write data |
| cr_rdata_o | output | CR_W | Registered control register read data |
| cfg_o | output | N_CR*CR_W | All control registers, flat |
| coef_addr_i | input | $clog2(SPK_LEN) | Datapath coefficient index |
| coef_o | output | N_PC*SMP_W | Coefficients at that index, per bank |
| sort_en_o | output | 1 | Sorting datapath enable |
| sort_vld_o | output | 1 | Sample valid toward the datapath |
| sort_data_o | output | SMP_W | Sample toward the datapath |

## Verification
Two functions can act in the same cycle. A coefficient load can write a bank index while the datapath reads that same index through its own read port. The bench provokes this by pointing `coef_addr_i` at the index about to be loaded during the load cycle. It expects the old coefficient on the next cycle and the new one on the cycle after. A second overlap is a register write followed at once by a read of the same address. That read must return the value just written.

// File: rtl/spk_mode_pkg.sv
package spk_mode_pkg;
  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_LOAD  = 3'd1,
    MD_WRITE = 3'd2,
    MD_READ  = 3'd3,
    MD_SORT  = 3'd4,
    MD_RESET = 3'd7
  } spk_mode_e;

  typedef struct packed {
    logic load;
    logic write;
    logic read;
    logic sort;
    logic clear;
  } spk_ctl_t;
endpackage

// File: rtl/spk_mode_decode.sv
module spk_mode_decode
  import spk_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  output spk_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (mode_i)
      MD_LOAD:  ctl_o.load  = 1'b1;
      MD_WRITE: ctl_o.write = 1'b1;
      MD_READ:  ctl_o.read  = 1'b1;
      MD_SORT:  ctl_o.sort  = 1'b1;
      MD_RESET: ctl_o.clear = 1'b1;
      default:  ctl_o = '0;
    endcase
    if (rst) begin
      ctl_o = '0;
      ctl_o.clear = 1'b1;
    end
  end

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_o.load, ctl_o.write, ctl_o.read, ctl_o.sort, ctl_o.clear})); // R1
  AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5 || mode_i == 3'd6) |-> (ctl_o == '0)); // R1
endmodule

// File: rtl/spk_coef_bank.sv
module spk_coef_bank #(
  parameter int SMP_W   = 12,
  parameter int SPK_LEN = 32,
  localparam int IW     = (SPK_LEN > 1) ? $clog2(SPK_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_mode,
  input  logic             wr_en,
  input  logic [SMP_W-1:0] wr_data,
  input  logic [IW-1:0]    rd_addr,
  output logic [SMP_W-1:0] rd_data
);
  localparam logic [IW-1:0] LAST = IW'(SPK_LEN - 1);

  logic [SMP_W-1:0] mem [SPK_LEN];
  logic [IW-1:0]    ptr;

  always_ff @(posedge clk) begin
    if (clear || !load_mode) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && load_mode && !clear) begin
      mem[ptr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST); // R3
  AST_PTR_LEAVE: assert property (@(posedge clk) disable iff (rst)
    !load_mode |=> (ptr == '0)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (load_mode && !wr_en && !clear) |=> $stable(ptr)); // R2
endmodule

// File: rtl/spk_cr_file.sv
module spk_cr_file #(
  parameter int N_CR = 16,
  parameter int CR_W = 16,
  localparam int AW  = (N_CR > 1) ? $clog2(N_CR) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [CR_W-1:0]      wdata,
  output logic [CR_W-1:0]      rdata,
  output logic [N_CR*CR_W-1:0] regs
);
  logic [N_CR*CR_W-1:0] cr_q;

  genvar k;
  generate
    for (k = 0; k < N_CR; k++) begin : g_reg
      always_ff @(posedge clk) begin
        if (clear) begin
          cr_q[k*CR_W +: CR_W] <= '0;
        end else if (wr_en && (addr == AW'(k))) begin
          cr_q[k*CR_W +: CR_W] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clear) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= cr_q[addr*CR_W +: CR_W];
    end
  end

  assign regs = cr_q;

  AST_CR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clear) |=> $stable(cr_q)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !clear) |=> $stable(rdata)); // R6
  AST_CR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cr_q == '0 && rdata == '0)); // R9
endmodule

// File: rtl/spk_mode_ctrl.sv
module spk_mode_ctrl
  import spk_mode_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int SPK_LEN = 32,
  parameter int N_PC    = 2,
  parameter int N_CR    = 16,
  parameter int CR_W    = 16,
  localparam int IW     = (SPK_LEN > 1) ? $clog2(SPK_LEN) : 1,
  localparam int AW     = (N_CR > 1) ? $clog2(N_CR) : 1,
  localparam int SW     = (N_PC > 1) ? $clog2(N_PC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            mode_i,
  input  logic                  smp_vld_i,
  input  logic [SMP_W-1:0]      smp_data_i,
  input  logic [SW-1:0]         pc_sel_i,
  input  logic [AW-1:0]         cr_addr_i,
  input  logic [CR_W-1:0]       cr_wdata_i,
  output logic [CR_W-1:0]       cr_rdata_o,
  output logic [N_CR*CR_W-1:0]  cfg_o,
  input  logic [IW-1:0]         coef_addr_i,
  output logic [N_PC*SMP_W-1:0] coef_o,
  output logic                  sort_en_o,
  output logic                  sort_vld_o,
  output logic [SMP_W-1:0]      sort_data_o
);
  spk_ctl_t ctl;

  spk_mode_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  genvar b;
  generate
    for (b = 0; b < N_PC; b++) begin : g_bank
      logic sel_hit;
      assign sel_hit = ctl.load && smp_vld_i && (pc_sel_i == SW'(b));
      spk_coef_bank #(.SMP_W(SMP_W), .SPK_LEN(SPK_LEN)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.clear),
        .load_mode (ctl.load),
        .wr_en     (sel_hit),
        .wr_data   (smp_data_i),
        .rd_addr   (coef_addr_i),
        .rd_data   (coef_o[b*SMP_W +: SMP_W])
      );
    end
  endgenerate

  spk_cr_file #(.N_CR(N_CR), .CR_W(CR_W)) u_cr (
    .clk   (clk),
    .rst   (rst),
    .clear (ctl.clear),
    .wr_en (ctl.write),
    .rd_en (ctl.read),
    .addr  (cr_addr_i),
    .wdata (cr_wdata_i),
    .rdata (cr_rdata_o),
    .regs  (cfg_o)
  );

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      sort_en_o   <= 1'b0;
      sort_vld_o  <= 1'b0;
      sort_data_o <= '0;
    end else begin
      sort_en_o  <= ctl.sort;
      sort_vld_o <= ctl.sort && smp_vld_i;
      if (ctl.sort && smp_vld_i) begin
        sort_data_o <= smp_data_i;
      end
    end
  end

  AST_SORT_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd4) |=> sort_en_o); // R7
  AST_SORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 3'd4) |=> (!sort_vld_o && !sort_en_o)); // R7
  AST_RESET_MODE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd7) |=> (!sort_en_o && cfg_o == '0 && cr_rdata_o == '0)); // R9
endmodule

// File: tb/sim_spk_mode_ctrl.sv
module sim_spk_mode_ctrl;
  localparam int SMP_W = 12, LEN = 32, NPC = 2, NCR = 16, CW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] mode;
  logic vld;
  logic [SMP_W-1:0] data;
  logic sel;
  logic [3:0] addr;
  logic [CW-1:0] wdata;
  logic [CW-1:0] rdata;
  logic [NCR*CW-1:0] cfg;
  logic [4:0] caddr;
  logic [NPC*SMP_W-1:0] coef;
  logic sen, svld;
  logic [SMP_W-1:0] sdata;

  int checks = 0;
  int fails = 0;
  logic [SMP_W-1:0] bank0 [LEN];
  logic [SMP_W-1:0] bank1 [LEN];

  always #5 clk = ~clk;

  spk_mode_ctrl u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .smp_vld_i(vld), .smp_data_i(data),
    .pc_sel_i(sel), .cr_addr_i(addr), .cr_wdata_i(wdata), .cr_rdata_o(rdata),
    .cfg_o(cfg), .coef_addr_i(caddr), .coef_o(coef), .sort_en_o(sen),
    .sort_vld_o(svld), .sort_data_o(sdata)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mode = 3'd0; vld = 1'b0; data = '0; sel = 1'b0; addr = '0; wdata = '0; caddr = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_inputs();
    step(); step();
    rst = 1'b0;
    chk("R9 cfg after reset", {31'd0, cfg == '0}, 32'd1);
    chk("R9 rdata after reset", rdata, 0);
    chk("R9 sort_en after reset", sen, 0);
  endtask

  task automatic t_load();
    mode = 3'd1;
    for (int i = 0; i < LEN; i++) begin
      vld = 1'b1; sel = 1'b0; data = SMP_W'(100 + i); bank0[i] = SMP_W'(100 + i); step();
      vld = 1'b0; data = 12'hFFF; step();
      vld = 1'b1; sel = 1'b1; data = SMP_W'(500 + i); bank1[i] = SMP_W'(500 + i); step();
    end
    vld = 1'b1; sel = 1'b0; data = 12'd900; bank0[0] = 12'd900; step();
    data = 12'd901; bank0[1] = 12'd901; step();
    idle_inputs(); step();
    mode = 3'd1; vld = 1'b1; sel = 1'b1; data = 12'd777; bank1[0] = 12'd777; step();
    idle_inputs();
    for (int i = 0; i < LEN; i += 5) begin
      caddr = 5'(i); step();
      chk("R2 bank0 load", coef[SMP_W-1:0], bank0[i]);
      chk("R2 bank1 load", coef[2*SMP_W-1:SMP_W], bank1[i]);
    end
    caddr = 5'd1; step();
    chk("R3 bank0 wrap idx1", coef[SMP_W-1:0], 12'd901);
    caddr = 5'd0; step();
    chk("R3 bank0 wrap idx0", coef[SMP_W-1:0], 12'd900);
    chk("R4 bank1 restart at 0", coef[2*SMP_W-1:SMP_W], 12'd777);
    caddr = 5'd2; step();
    chk("R4 bank1 idx2 untouched", coef[2*SMP_W-1:SMP_W], bank1[2]);
  endtask

  task automatic t_collide();
    mode = 3'd1; vld = 1'b1; sel = 1'b0; data = 12'h3A5; caddr = 5'd0; step();
    chk("R10 read-first old value", coef[SMP_W-1:0], bank0[0]);
    bank0[0] = 12'h3A5;
    idle_inputs(); caddr = 5'd0; step();
    chk("R10 new value next cycle", coef[SMP_W-1:0], 12'h3A5);
  endtask

  task automatic t_regs();
    for (int k = 0; k < NCR; k++) begin
      mode = 3'd2; addr = 4'(k); wdata = CW'(16'hA000 + k * 17); step();
    end
    chk("R5 reg5 in cfg", cfg[5*CW +: CW], 16'hA000 + 5 * 17);
    chk("R5 reg15 in cfg", cfg[15*CW +: CW], 16'hA000 + 15 * 17);
    mode = 3'd2; addr = 4'd3; wdata = 16'hBEEF; step();
    mode = 3'd3; addr = 4'd3; step();
    chk("R6 read after write", rdata, 16'hBEEF);
    mode = 3'd3; addr = 4'd9; step();
    chk("R6 read reg9", rdata, 16'hA000 + 9 * 17);
    mode = 3'd0; addr = 4'd3; step();
    chk("R6 hold outside read", rdata, 16'hA000 + 9 * 17);
  endtask

  task automatic t_sort();
    mode = 3'd4; vld = 1'b1; data = 12'h055; step();
    chk("R7 sort_en", sen, 1);
    chk("R7 sort_vld", svld, 1);
    chk("R7 sort_data", sdata, 12'h055);
    vld = 1'b0; data = 12'h0AA; step();
    chk("R7 vld low forwarded", svld, 0);
    chk("R7 en stays", sen, 1);
    mode = 3'd0; vld = 1'b1; step();
    chk("R7 en off after sort", sen, 0);
    chk("R7 vld off after sort", svld, 0);
  endtask

  task automatic t_idle();
    logic [NCR*CW-1:0] snap;
    snap = cfg;
    for (int m = 0; m < 3; m++) begin
      mode = (m == 0) ? 3'd0 : ((m == 1) ? 3'd5 : 3'd6);
      vld = 1'b1; sel = 1'b0; data = 12'h111; addr = 4'd2; wdata = 16'h1234; caddr = 5'd0;
      step();
    end
    mode = 3'd0; vld = 1'b0; step();
    chk("R8 cfg unchanged", {31'd0, cfg == snap}, 32'd1);
    chk("R1 code5/6 no load", coef[SMP_W-1:0], bank0[0]);
    chk("R8 rdata unchanged", rdata, 16'hA000 + 9 * 17);
    chk("R1 code5/6 no sort", sen, 0);
  endtask

  task automatic t_mode_reset();
    mode = 3'd3; addr = 4'd4; step();
    mode = 3'd7; step();
    idle_inputs(); caddr = 5'd3; step();
    chk("R9 mode7 clears cfg", {31'd0, cfg == '0}, 32'd1);
    chk("R9 mode7 clears rdata", rdata, 0);
    chk("R9 coef kept", coef[2*SMP_W-1:SMP_W], bank1[3]);
    mode = 3'd1; vld = 1'b1; sel = 1'b0; data = 12'h0CC; step();
    idle_inputs(); caddr = 5'd0; step();
    chk("R9 pointer cleared", coef[SMP_W-1:0], 12'h0CC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_collide();
    t_regs();
    t_sort();
    t_idle();
    t_mode_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule